// File: doc/BRIEF.md
# SCSI Bus Mode Change Controller

This block chooses the termination mode for a multimode SCSI bus terminator. Two comparators watch the DIFFSENS line and feed it pre-synchronized bits. The block decodes those bits into a detected bus mode: single-ended (SE), low-voltage differential (LVD) or high-power differential (HPD). A detected mode becomes the mode in effect only after it has been seen without a break for a programmable number of clock cycles. That filter takes the place of a large analog low-pass filter and gives the mode change delay the bus standard requires. A typical setting is 200 ms worth of cycles.

The mode in effect drives three things: the termination configuration (high impedance, SE network or LVD network), two status outputs, and the enable of the DIFFSENS bias regulator. A disable input disconnects the terminator from the bus while detection and status reporting keep running. A supply-good input that drops forces high impedance and returns the block to its power-up state. The analog comparators, regulators and impedance networks lie outside the block.

Top module: `termination_mode_ctrl`

## Requirements
- R1: The comparator bits decode as follows. `above_high_i`=1 means HPD, and this includes the otherwise invalid combination `above_low_i`=0, `above_high_i`=1. `above_low_i`=1 with `above_high_i`=0 means LVD. Both bits 0 means SE.
- R2: After reset, no mode is in effect. `term_cfg_o` is 2'b00 (high-Z), both status outputs are low and `bias_en_o` is low until a mode is accepted.
- R3: A detected mode that differs from the mode in effect is adopted at the clock edge where it has been sampled on SETTLE_CYCLES consecutive edges. The outputs change right after that edge and not one edge earlier.
- R4: The settle count starts again under either of two conditions: the detected mode returns to the mode in effect, or it moves to a third mode. A new candidate counts from one.
- R5: `term_cfg_o` encodes the configuration as 2'b00 for high-Z, 2'b01 for SE termination and 2'b10 for LVD termination. When the block is enabled and powered, SE maps to 2'b01, LVD maps to 2'b10, and HPD maps to 2'b00.
- R6: `stat_se_o` is high exactly when SE is in effect, and `stat_lvd_o` is high exactly when LVD is in effect. In HPD, and before any mode is accepted, both are low.
- R7: While `term_off_i` is high, `term_cfg_o` is 2'b00 and `bias_en_o` is low in the same cycle. Mode detection, the delay filter and the status outputs keep operating, so a mode can be accepted while the block is disabled.
- R8: `bias_en_o` is high exactly when `term_off_i` is low, `supply_ok_i` is high and SE or LVD is in effect.
- R9: While `supply_ok_i` is low, `term_cfg_o` is 2'b00 and `bias_en_o` is low in the same cycle. At the next edge the accepted mode and the count are cleared, so once the supply returns a mode needs the full delay again.
- R10: A synchronous reset returns the block to the high-Z state with no mode and clears a count in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| above_low_i | input | 1 | DIFFSENS level above the SE/LVD threshold |
| above_high_i | input | 1 | DIFFSENS level above the LVD/HPD threshold |
| term_off_i | input | 1 | Disconnect request; high forces high-Z |
| supply_ok_i | input | 1 | Terminator supply present |
| term_cfg_o | output | 2 | Termination configuration (00 high-Z, 01 SE, 10 LVD) |
| stat_se_o | output | 1 | SE mode in effect |
| stat_lvd_o | output | 1 | LVD mode in effect |
| bias_en_o | output | 1 | DIFFSENS bias regulator enable |

## Verification
The bench builds the block with SETTLE_CYCLES set to 16 instead of millions of cycles. With that value, random hold times of 1 to 32 cycles land on both sides of the settle boundary. The exact edge of adoption, interrupted candidates and third-mode restarts can then all be reached within a few thousand cycles. Directed sequences pin down the edge at count 15 versus 16, the invalid comparator combination, disable while a change is pending, supply loss, and a reset in the middle of a count.

// File: rtl/term_mode_pkg.sv
package term_mode_pkg;

    // Mode in effect / detected on the bus
    typedef enum logic [1:0] {
        BM_NONE = 2'd0,
        BM_SE   = 2'd1,
        BM_LVD  = 2'd2,
        BM_HPD  = 2'd3
    } bus_mode_e;

    // Termination network selection driven to the analog side
    typedef enum logic [1:0] {
        TC_HIZ = 2'd0,
        TC_SE  = 2'd1,
        TC_LVD = 2'd2
    } term_cfg_e;

endpackage

// File: rtl/diffsense_level_decode.sv
module diffsense_level_decode
    import term_mode_pkg::*;
(
    input  logic      above_low_i,
    input  logic      above_high_i,
    output bus_mode_e mode_o
);

    // The high comparator wins: an invalid high-without-low reading is
    // treated as HPD so the terminator stays off the bus.
    always_comb begin
        if (above_high_i) begin
            mode_o = BM_HPD;
        end else if (above_low_i) begin
            mode_o = BM_LVD;
        end else begin
            mode_o = BM_SE;
        end
    end

endmodule

// File: rtl/mode_settle_filter.sv
module mode_settle_filter
    import term_mode_pkg::*;
#(
    parameter int SETTLE_CYCLES = 20_000_000
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      supply_ok_i,
    input  bus_mode_e det_i,
    output bus_mode_e acc_o
);

    localparam int CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT    = CW'(SETTLE_CYCLES);
    localparam logic [CW-1:0] LAST_CNT = CW'(SETTLE_CYCLES - 1);

    typedef struct packed {
        bus_mode_e     acc;
        bus_mode_e     cand;
        logic [CW-1:0] cnt;
    } settle_state_t;

    localparam settle_state_t IDLE_ST = '{acc: BM_NONE, cand: BM_NONE, cnt: '0};

    settle_state_t st_d, st_q;
    logic [CW-1:0] run_d;

    always_comb begin
        st_d  = st_q;
        run_d = '0;
        if (!supply_ok_i) begin
            st_d = IDLE_ST;
        end else if (det_i == st_q.acc) begin
            st_d.cand = st_q.acc;
            st_d.cnt  = '0;
        end else begin
            run_d = (det_i == st_q.cand) ? (st_q.cnt + CW'(1)) : CW'(1);
            if (run_d == LIMIT) begin
                st_d.acc  = det_i;
                st_d.cand = det_i;
                st_d.cnt  = '0;
            end else begin
                st_d.cand = det_i;
                st_d.cnt  = run_d;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= IDLE_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o = st_q.acc;

    // R3
    adopt_matches_det_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.acc != $past(st_q.acc) && st_q.acc != BM_NONE) |-> (st_q.acc == $past(det_i)));

    // R3
    settle_elapsed_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.acc != $past(st_q.acc) && st_q.acc != BM_NONE) |-> ($past(st_q.cnt) == LAST_CNT));

    // R4
    cnt_below_limit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.cnt < LIMIT);

    // R9
    supply_loss_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !supply_ok_i |=> (st_q.acc == BM_NONE && st_q.cnt == '0));

endmodule

// File: rtl/term_output_map.sv
module term_output_map
    import term_mode_pkg::*;
(
    input  bus_mode_e acc_i,
    input  logic      term_off_i,
    input  logic      supply_ok_i,
    output term_cfg_e cfg_o,
    output logic      stat_se_o,
    output logic      stat_lvd_o,
    output logic      bias_en_o
);

    always_comb begin
        cfg_o      = TC_HIZ;
        bias_en_o  = 1'b0;
        stat_se_o  = (acc_i == BM_SE);
        stat_lvd_o = (acc_i == BM_LVD);
        if (supply_ok_i && !term_off_i) begin
            case (acc_i)
                BM_SE: begin
                    cfg_o     = TC_SE;
                    bias_en_o = 1'b1;
                end
                BM_LVD: begin
                    cfg_o     = TC_LVD;
                    bias_en_o = 1'b1;
                end
                default: begin
                    cfg_o     = TC_HIZ;
                    bias_en_o = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/termination_mode_ctrl.sv
module termination_mode_ctrl
    import term_mode_pkg::*;
#(
    parameter int SETTLE_CYCLES = 20_000_000
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       above_low_i,
    input  logic       above_high_i,
    input  logic       term_off_i,
    input  logic       supply_ok_i,
    output logic [1:0] term_cfg_o,
    output logic       stat_se_o,
    output logic       stat_lvd_o,
    output logic       bias_en_o
);

    bus_mode_e det_mode;
    bus_mode_e acc_mode;
    term_cfg_e cfg;

    diffsense_level_decode i_decode (
        .above_low_i  (above_low_i),
        .above_high_i (above_high_i),
        .mode_o       (det_mode)
    );

    mode_settle_filter #(
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) i_filter (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .supply_ok_i (supply_ok_i),
        .det_i       (det_mode),
        .acc_o       (acc_mode)
    );

    term_output_map i_outmap (
        .acc_i       (acc_mode),
        .term_off_i  (term_off_i),
        .supply_ok_i (supply_ok_i),
        .cfg_o       (cfg),
        .stat_se_o   (stat_se_o),
        .stat_lvd_o  (stat_lvd_o),
        .bias_en_o   (bias_en_o)
    );

    assign term_cfg_o = cfg;

    // R2
    no_mode_after_reset_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> (term_cfg_o == 2'b00 && !stat_se_o && !stat_lvd_o && !bias_en_o));

    // R5
    hpd_hiz_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_mode == BM_HPD) |-> (term_cfg_o == 2'b00 && !stat_se_o && !stat_lvd_o));

    // R6
    status_exclusive_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(stat_se_o && stat_lvd_o));

    // R7
    disable_hiz_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        term_off_i |-> (term_cfg_o == 2'b00 && !bias_en_o));

    // R8
    bias_matches_cfg_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        bias_en_o == (term_cfg_o != 2'b00));

endmodule

// File: tb/test_termination_mode_ctrl.sv
module test_termination_mode_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       above_low = 1'b0;
    logic       above_high = 1'b0;
    logic       term_off = 1'b0;
    logic       supply_ok = 1'b1;
    logic [1:0] term_cfg;
    logic       stat_se, stat_lvd, bias_en;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // reference model state: 0 none, 1 SE, 2 LVD, 3 HPD
    int m_acc = 0;
    int m_cand = 0;
    int m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    termination_mode_ctrl #(.SETTLE_CYCLES(SETTLE)) i_termination_mode_ctrl (
        .clk_i        (clk),
        .rst_i        (rst),
        .above_low_i  (above_low),
        .above_high_i (above_high),
        .term_off_i   (term_off),
        .supply_ok_i  (supply_ok),
        .term_cfg_o   (term_cfg),
        .stat_se_o    (stat_se),
        .stat_lvd_o   (stat_lvd),
        .bias_en_o    (bias_en)
    );

    function automatic int decode(logic lo, logic hi);
        if (hi) return 3;   // R1: high bit alone or with low bit means HPD
        if (lo) return 2;
        return 1;
    endfunction

    function automatic int exp_cfg();
        if (term_off || !supply_ok) return 0;
        if (m_acc == 1) return 1;
        if (m_acc == 2) return 2;
        return 0;
    endfunction

    always @(posedge clk) begin
        int det, run;
        det = decode(above_low, above_high);
        if (rst || !supply_ok) begin
            m_acc = 0; m_cand = 0; m_cnt = 0;
        end else if (det == m_acc) begin
            m_cand = m_acc; m_cnt = 0;
        end else begin
            run = (det == m_cand) ? m_cnt + 1 : 1;
            if (run >= SETTLE) begin
                m_acc = det; m_cand = det; m_cnt = 0;
            end else begin
                m_cand = det; m_cnt = run;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cmp_model();
        chk("R5 term_cfg vs model", int'(term_cfg), exp_cfg());
        chk("R6 stat_se vs model", int'(stat_se), (m_acc == 1) ? 1 : 0);
        chk("R6 stat_lvd vs model", int'(stat_lvd), (m_acc == 2) ? 1 : 0);
        chk("R8 bias_en vs model", int'(bias_en), (exp_cfg() != 0) ? 1 : 0);
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic lo, input logic hi);
        above_low  = lo;
        above_high = hi;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed_init;
        int hold;
        seed_init = $urandom(32'd7041);
        hold = 0;

        // R2: reset state
        drive(1'b0, 1'b0);
        step(3);
        rst = 1'b0;
        #1;
        chk("R2 cfg after reset", int'(term_cfg), 0);
        chk("R2 status after reset", int'({stat_se, stat_lvd}), 0);
        chk("R2 bias after reset", int'(bias_en), 0);

        // R3: exact adoption edge for SE
        step(15);
        chk("R3 cfg before delay", int'(term_cfg), 0);
        step(1);
        chk("R3 cfg at delay", int'(term_cfg), 1);
        chk("R6 stat_se in SE", int'(stat_se), 1);
        chk("R8 bias in SE", int'(bias_en), 1);

        // R4: glitch back to current mode restarts the count
        drive(1'b1, 1'b0); step(10);
        drive(1'b0, 1'b0); step(1);
        drive(1'b1, 1'b0); step(15);
        chk("R4 return restarts count", int'(term_cfg), 1);
        step(1);
        chk("R4 LVD adopted after full run", int'(term_cfg), 2);
        chk("R6 stat_lvd in LVD", int'(stat_lvd), 1);

        // R1: invalid combination continues an HPD run
        drive(1'b1, 1'b1); step(10);
        drive(1'b0, 1'b1); step(5);
        chk("R1 HPD run not yet complete", int'(term_cfg), 2);
        step(1);
        chk("R1 invalid combo counted as HPD", int'(term_cfg), 0);
        chk("R6 status low in HPD", int'({stat_se, stat_lvd}), 0);
        chk("R5 bias off in HPD", int'(bias_en), 0);

        // R4: move to a third mode restarts the count at one
        drive(1'b1, 1'b0); step(10);
        drive(1'b0, 1'b0); step(15);
        chk("R4 third mode restarts", int'(term_cfg), 0);
        chk("R4 status still HPD", int'({stat_se, stat_lvd}), 0);
        step(1);
        chk("R4 third mode adopted", int'(term_cfg), 1);

        // R7: disable while detection keeps running
        term_off = 1'b1;
        #1;
        chk("R7 cfg forced high-Z", int'(term_cfg), 0);
        chk("R7 bias off", int'(bias_en), 0);
        chk("R7 status kept", int'(stat_se), 1);
        drive(1'b1, 1'b0);
        step(16);
        chk("R7 LVD accepted while disabled", int'(stat_lvd), 1);
        chk("R7 cfg still high-Z", int'(term_cfg), 0);
        term_off = 1'b0;
        #1;
        chk("R7 enable applies LVD", int'(term_cfg), 2);
        chk("R8 bias back on", int'(bias_en), 1);

        // R9: supply loss
        supply_ok = 1'b0;
        #1;
        chk("R9 cfg high-Z on supply loss", int'(term_cfg), 0);
        chk("R9 bias off on supply loss", int'(bias_en), 0);
        step(1);
        chk("R9 mode cleared", int'({stat_se, stat_lvd}), 0);
        supply_ok = 1'b1;
        step(15);
        chk("R9 full delay again", int'(term_cfg), 0);
        step(1);
        chk("R9 LVD after supply return", int'(term_cfg), 2);

        // R10: reset in the middle of a count
        drive(1'b0, 1'b0); step(10);
        rst = 1'b1; step(1);
        rst = 1'b0;
        #1;
        chk("R10 high-Z after reset", int'(term_cfg), 0);
        chk("R10 status cleared", int'(stat_lvd), 0);
        step(15);
        chk("R10 count cleared", int'(stat_se), 0);
        step(1);
        chk("R10 SE after full delay", int'(term_cfg), 1);

        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            if (hold == 0) begin
                int r;
                r = $urandom_range(0, 3);
                drive(r[0], r[1]);
                hold = $urandom_range(1, 2 * SETTLE);
                term_off  = ($urandom_range(0, 9) == 0);
                supply_ok = ($urandom_range(0, 29) != 0);
            end
            rst = ($urandom_range(0, 299) == 0);
            hold--;
            #1;
            cmp_model();
            step(1);
        end
        rst = 1'b0;
        finish_run();
    end

endmodule